// File: doc/BRIEF.md
# Successive-approximation trim controller

This block tunes a crystal oscillator by stepping a signed load-capacitance trim code through a binary search. The code counts units of 0.25 pF in two's complement. Each trim value is presented on the trim code output together with a one-cycle write strobe. The block then waits a programmable number of clock cycles so the oscillator can settle, and asks an external measurement unit whether the oscillator now runs fast, runs slow, or sits exactly on frequency.

The search starts with a write of zero followed by one measurement. The starting point of the search is asymmetric: a fast verdict jumps to +4 pF and a slow verdict jumps to -8 pF. After that, each fast verdict adds the current step and each slow verdict removes it. The step starts at 2 pF and halves down to 0.25 pF. An exact verdict at any measurement stops the search. Once the 0.25 pF adjustment has been written and measured, the block reports done and holds its code until the next start.

Top module: `sar_trim_ctrl`

## Requirements
- R1: While reset is held and in the first cycles after it, trim_code_o is 0 and trim_wr_o, meas_req_o, busy_o and done_o are all low.
- R2: A start_i pulse while the block is not busy produces, in the next cycle, trim_wr_o high for exactly one cycle with trim_code_o equal to 0, and busy_o high.
- R3: After every trim_wr_o cycle, meas_req_o stays low for exactly SETTLE_CYC cycles and then rises. It stays high until a cycle with meas_valid_i high. meas_valid_i has no effect while meas_req_o is low.
- R4: The verdict meas_verdict_i is decoded as 2'b01 fast, 2'b10 slow, and any other value exact. For the first verdict after start, fast sets the code to +16 (+4 pF), slow sets it to -32 (-8 pF), and exact ends the search at 0.
- R5: For each later verdict, fast adds the current step to the code and slow subtracts it. The steps are 8, 4, 2 and 1 units, in that order, and each new code is written with trim_wr_o.
- R6: An exact verdict at any measurement ends the search at once. The current code is kept and no further write follows.
- R7: The verdict that follows the 1-unit adjustment ends the search whatever its value. One run therefore makes at most 6 writes.
- R8: trim_code_o never leaves the range -63 to +31 (-15.75 pF to +7.75 pF).
- R9: After the search ends, done_o is high, busy_o is low and trim_code_o is held unchanged until the next start_i. A start_i while busy_o is high is ignored, and a start_i while done_o is high begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new search (ignored while busy) |
| meas_valid_i | input | 1 | Verdict on meas_verdict_i is valid this cycle |
| meas_verdict_i | input | 2 | 01 fast, 10 slow, other values exact |
| trim_code_o | output | CODE_W | Signed trim code in 0.25 pF units |
| trim_wr_o | output | 1 | One-cycle strobe: write trim_code_o to the capacitor array |
| meas_req_o | output | 1 | Measurement request, held until answered |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished; code held |

## Verification
A wrong step register or a wrong initial-jump flag shows up as a wrong code at the very next write strobe, one settle-and-measure round after the verdict that caused it. A search that runs one step too many or too few shows up as a changed write count and a changed final code. A faulty settle counter moves the rising edge of meas_req_o away from exactly SETTLE_CYC+1 cycles after the strobe, so the first measurement of a run already exposes it. Search targets across the whole code range, both sides of zero and beyond the reachable limits make every branch and every step size reach the ports.

// File: rtl/trim_pkg.sv
package trim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_MEASURE,
    ST_DONE
  } trim_state_e;

  typedef enum logic [1:0] {
    VD_EXACT = 2'b00,
    VD_FAST  = 2'b01,
    VD_SLOW  = 2'b10,
    VD_RSVD  = 2'b11
  } verdict_e;

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_RUNS_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (SETTLE_CYC > 1) ? !expired_o : expired_o); // R3

endmodule

// File: rtl/trim_code_unit.sv
module trim_code_unit #(
  parameter int CODE_W     = 7,
  parameter int FAST_INIT  = 16,
  parameter int SLOW_INIT  = -32,
  parameter int FIRST_STEP = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     upd_i,
  input  logic                     fast_i,
  output logic signed [CODE_W-1:0] code_o,
  output logic                     last_o
);
  localparam int STEP_W  = $clog2(FIRST_STEP) + 1;
  localparam int CODE_HI = FAST_INIT + 2 * FIRST_STEP - 1;
  localparam int CODE_LO = SLOW_INIT - 2 * FIRST_STEP + 1;
  localparam logic signed [CODE_W-1:0] FAST_CODE = CODE_W'(FAST_INIT);
  localparam logic signed [CODE_W-1:0] SLOW_CODE = CODE_W'(SLOW_INIT);
  localparam logic [STEP_W-1:0]        STEP_INIT = STEP_W'(FIRST_STEP);

  logic signed [CODE_W-1:0] code_q, code_d;
  logic signed [CODE_W-1:0] step_ext;
  logic [STEP_W-1:0]        step_q, step_d;
  logic                     first_q, first_d;
  logic                     reg_en;

  assign step_ext = CODE_W'(step_q);
  assign reg_en   = clr_i | upd_i;

  always_comb begin
    code_d  = code_q;
    step_d  = step_q;
    first_d = first_q;
    if (clr_i) begin
      code_d  = '0;
      step_d  = STEP_INIT;
      first_d = 1'b1;
    end else if (upd_i) begin
      if (first_q) begin
        code_d  = fast_i ? FAST_CODE : SLOW_CODE;
        first_d = 1'b0;
      end else begin
        code_d = fast_i ? (code_q + step_ext) : (code_q - step_ext);
        step_d = step_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      step_q  <= STEP_INIT;
      first_q <= 1'b1;
    end else if (reg_en) begin
      code_q  <= code_d;
      step_q  <= step_d;
      first_q <= first_d;
    end
  end

  assign code_o = code_q;
  assign last_o = !first_q && (step_q == '0);

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q >= CODE_LO) && (code_q <= CODE_HI)); // R8

  AST_FIRST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && first_q && !clr_i) |=> (code_q == FAST_CODE) || (code_q == SLOW_CODE)); // R4

endmodule

// File: rtl/trim_fsm.sv
module trim_fsm
  import trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       settle_done_i,
  input  logic       meas_valid_i,
  input  logic [1:0] verdict_i,
  input  logic       last_i,
  output logic       clr_o,
  output logic       upd_o,
  output logic       fast_o,
  output logic       load_o,
  output logic       wr_o,
  output logic       req_o,
  output logic       busy_o,
  output logic       done_o
);
  trim_state_e state_q, state_d;
  logic        is_step;

  assign is_step = (verdict_i == VD_FAST) || (verdict_i == VD_SLOW);
  assign fast_o  = (verdict_i == VD_FAST);

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    upd_o   = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        load_o  = 1'b1;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_done_i) state_d = ST_MEASURE;
      end
      ST_MEASURE: begin
        if (meas_valid_i) begin
          if (is_step && !last_i) begin
            upd_o   = 1'b1;
            state_d = ST_WRITE;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign wr_o   = (state_q == ST_WRITE);
  assign req_o  = (state_q == ST_MEASURE);
  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o); // R2

  AST_NO_REQ_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !req_o); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !meas_valid_i) |=> req_o); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R9

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R9

  AST_EXACT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && meas_valid_i && !is_step) |=> done_o && !wr_o); // R6

endmodule

// File: rtl/sar_trim_ctrl.sv
module sar_trim_ctrl #(
  parameter int CODE_W     = 7,
  parameter int SETTLE_CYC = 16,
  parameter int FAST_INIT  = 16,
  parameter int SLOW_INIT  = -32,
  parameter int FIRST_STEP = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     meas_valid_i,
  input  logic [1:0]               meas_verdict_i,
  output logic signed [CODE_W-1:0] trim_code_o,
  output logic                     trim_wr_o,
  output logic                     meas_req_o,
  output logic                     busy_o,
  output logic                     done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       clr, upd, fast, load, settle_done, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trim_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_i),
    .settle_done_i (settle_done),
    .meas_valid_i  (meas_valid_i),
    .verdict_i     (meas_verdict_i),
    .last_i        (last),
    .clr_o         (clr),
    .upd_o         (upd),
    .fast_o        (fast),
    .load_o        (load),
    .wr_o          (trim_wr_o),
    .req_o         (meas_req_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  trim_settle_timer #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .expired_o (settle_done)
  );

  trim_code_unit #(
    .CODE_W     (CODE_W),
    .FAST_INIT  (FAST_INIT),
    .SLOW_INIT  (SLOW_INIT),
    .FIRST_STEP (FIRST_STEP)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .upd_i  (upd),
    .fast_i (fast),
    .code_o (trim_code_o),
    .last_o (last)
  );

  AST_DONE_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !start_i) |=> $stable(trim_code_o)); // R9

  AST_START_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !busy_o) |=> trim_wr_o && (trim_code_o == '0)); // R2

endmodule

// File: tb/sim_sar_trim_ctrl.sv
module sim_sar_trim_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;
  localparam int RESP_LAT   = 2;
  localparam int NV         = 12;

  // target code, expected final code, expected write count
  localparam int V_TGT [NV] = '{0, 16, 31, 40, -32, -63, -20, 5, 1, -1, 23, 12};
  localparam int V_FIN [NV] = '{0, 16, 31, 31, -32, -47, -20, 5, 1, -17, 23, 12};
  localparam int V_WRS [NV] = '{1, 2, 6, 6, 2, 6, 4, 6, 6, 6, 6, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic resp_valid = 1'b0;
  logic inj_valid = 1'b0;
  logic [1:0] resp_verdict = 2'b00;
  logic [1:0] inj_verdict = 2'b00;
  logic signed [6:0] trim_code;
  logic trim_wr, meas_req, busy, done;

  int n_checks = 0;
  int n_fail = 0;
  int target = 0;
  bit force_rsvd = 1'b0;
  int wr_cnt = 0;
  int gap = 0;
  bit req_prev = 1'b0;
  int lat_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_trim_ctrl #(.CODE_W(7), .SETTLE_CYC(SETTLE)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .meas_valid_i   (resp_valid | inj_valid),
    .meas_verdict_i (inj_valid ? inj_verdict : resp_verdict),
    .trim_code_o    (trim_code),
    .trim_wr_o      (trim_wr),
    .meas_req_o     (meas_req),
    .busy_o         (busy),
    .done_o         (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Measurement model: fast when code is below target, slow above, exact on it.
  always @(negedge clk) begin
    int c;
    c = int'(trim_code);
    if (resp_valid) begin
      resp_valid = 1'b0;
    end else if (meas_req) begin
      if (lat_cnt >= RESP_LAT) begin
        lat_cnt = 0;
        resp_valid = 1'b1;
        if (force_rsvd)       resp_verdict = 2'b11;
        else if (c == target) resp_verdict = 2'b00;
        else if (c < target)  resp_verdict = 2'b01;
        else                  resp_verdict = 2'b10;
      end else begin
        lat_cnt++;
      end
    end
  end

  // Monitor: write count, code range on every write, settle gap on every request.
  always @(negedge clk) begin
    if (rst_n) begin
      if (trim_wr) begin
        wr_cnt++;
        gap = 0;
        check(int'(trim_code) >= -63 && int'(trim_code) <= 31, "R8",
              "code range on write", int'(trim_code), 0);
      end else begin
        gap++;
      end
      if (meas_req && !req_prev)
        check(gap == SETTLE + 1, "R3", "write-to-request gap", gap, SETTLE + 1);
      req_prev = meas_req;
    end
  end

  task automatic run_case(input int tgt, input int exp_fin, input int exp_wr,
                          input bit mid_start);
    int guard;
    target = tgt;
    wr_cnt = 0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && trim_wr && trim_code == 0, "R2", "start writes zero and busy",
          {busy, trim_wr}, 3);
    if (mid_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;  // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(done && !busy, "R7", "search completes", done, 1);
    check(int'(trim_code) == exp_fin, "R5", "final code", int'(trim_code), exp_fin);
    check(wr_cnt == exp_wr, "R6", "write count", wr_cnt, exp_wr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(trim_code == 0 && !trim_wr && !meas_req && !busy && !done, "R1",
          "outputs in reset", {trim_wr, meas_req, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(trim_code == 0 && !trim_wr && !meas_req && !busy && !done, "R1",
          "outputs after reset release", {trim_wr, meas_req, busy, done}, 0);

    // R4 R5 R6 R7: table of targets walked one after another (restart from done)
    for (int i = 0; i < NV; i++) begin
      run_case(V_TGT[i], V_FIN[i], V_WRS[i], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: done and code held, no writes while idle in done
    wr_cnt = 0;
    repeat (30) @(negedge clk);
    check(done && int'(trim_code) == 12 && wr_cnt == 0, "R9", "code held after done",
          int'(trim_code), 12);

    // R3: a verdict without a request has no effect
    inj_verdict = 2'b01;
    inj_valid   = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(done && !trim_wr && int'(trim_code) == 12 && wr_cnt == 0, "R3",
          "unrequested verdict ignored", int'(trim_code), 12);

    // R9: a second start in mid-search is ignored
    run_case(5, 5, 6, 1'b1);
    repeat (2) @(negedge clk);

    // R4: reserved verdict 11 counts as exact on the first measurement
    force_rsvd = 1'b1;
    run_case(20, 0, 1, 1'b0);
    force_rsvd = 1'b0;
    repeat (2) @(negedge clk);

    // R4: slow first verdict lands on -32 in the second write
    run_case(-32, -32, 2, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule